// File: doc/BRIEF.md
# Byte-Wide EEPROM Page-Write Model

This block is a clocked, synthesizable model of the device side of a byte-wide parallel EEPROM that programs a whole page in one self-timed operation. A host drives chip-enable, write-enable and output-enable low-active strobes, an address and a data byte. Each write strobe (chip-enable and write-enable both low) loads one byte into a 64-entry page buffer. The address is taken when the strobe opens and the data when it closes. Loads that follow each other closely enough form one page. Once the strobes have stayed idle long enough, the block programs the loaded bytes into its internal array on its own.

While a page is being loaded or programmed, the block pulls its open-drain busy line. A read issued during programming returns the last loaded byte with bit 7 inverted, so a host can poll for completion. A low-active protect input blocks reads, loads and commits. All time limits are counted in clock cycles and set by parameters. All strobe inputs are expected to be synchronous to `clk_i`.

Top module: `eep_page_ctrl`

## Requirements
- R1: A write strobe is the interval in which `ce_ni` and `we_ni` are both low while `prot_ni` is high and `oe_ni` is ignored. The address is captured on the first clock of the strobe and the data byte on the first clock after it closes. `addr_i[7:6]` of the first load of a page selects the page, and `addr_i[5:0]` of each load selects the byte within it.
- R2: In a page, a strobe joins the page only if its first clock comes no more than `WIN_CYC` (6) cycles after the first clock of the previous accepted strobe. A later strobe is ignored.
- R3: `IDLE_CYC` (20) cycles after the last accepted strobe closes, programming starts. Only the loaded byte positions of the selected page change. If an offset is loaded twice, the later byte wins.
- R4: A read (`ce_ni`=0, `oe_ni`=0, `we_ni`=1, `prot_ni`=1) during programming returns the last loaded byte with bit 7 inverted and bits 6:0 unchanged.
- R5: `busy_od_o` is 1 from the cycle after the first accepted strobe opens until programming ends. It is 0 otherwise.
- R6: Programming lasts `PROG_CYC` (80) cycles. After it ends, reads return the array contents on all eight bits.
- R7: While `prot_ni` is low, strobes are ignored and `data_oe_o` stays 0. A commit cycle that runs with `prot_ni` low leaves the array unchanged.
- R8: Strobes issued during programming are ignored. They neither change the array nor start a new page.
- R9: After reset, `busy_od_o` is 0 and every array byte reads 0x00.
- R10: `data_oe_o` is 1 exactly while a read is active. `data_o` is 0x00 when `data_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| prot_ni | input | 1 | Protect, active low; inhibits reads, loads and commits |
| addr_i | input | 8 | Byte address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data or status byte |
| data_oe_o | output | 1 | Data output drive enable |
| busy_od_o | output | 1 | 1 = pull the open-drain ready/busy line low |

## Verification
The assertions assume that `prot_ni` does not fall while a write strobe is open, and that inputs change only between clock edges. The stimulus meets both conditions. Every input is changed on the falling clock edge. Protect is lowered only while the strobes are idle. Strobe spacing is chosen at random, either inside the window or deliberately past it, and programming is always allowed to finish before a new page begins, except in the case that tests loads during programming.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eep_state_e;
endpackage

// File: rtl/eep_strobe.sv
module eep_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic start_o,
  output logic end_o
);
  logic act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_i;
  end

  assign start_o = act_i & ~act_q;
  assign end_o   = ~act_i & act_q;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_off_i,
  input  logic [7:0]        wr_data_i,
  input  logic              clr_i,
  input  logic [PAGE_W-1:0] rd_off_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_vld_o
);
  localparam int PAGE_B = 1 << PAGE_W;

  logic [PAGE_B-1:0] vld_q;
  logic [7:0]        byte_q [PAGE_B];

  for (genvar g = 0; g < PAGE_B; g++) begin : g_ent
    wire hit = wr_i && (wr_off_i == PAGE_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    vld_q[g] <= 1'b0;
      else if (clr_i) vld_q[g] <= 1'b0;
      else if (hit)   vld_q[g] <= 1'b1;
    end
    always_ff @(posedge clk_i) begin
      if (hit) byte_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = byte_q[rd_off_i];
  assign rd_vld_o  = vld_q[rd_off_i];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PAGE_W   = 6,
  parameter int WIN_CYC  = 6,
  parameter int IDLE_CYC = 20,
  parameter int PROG_CYC = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              prot_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              busy_od_o
);
  localparam int PAGE_B = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int FC_W   = $clog2(WIN_CYC + 1);
  localparam int IC_W   = $clog2(IDLE_CYC + 1);
  localparam int PC_W   = $clog2(PROG_CYC + 1);

  eep_state_e        st_q;
  logic [HI_W-1:0]   page_q;
  logic [PAGE_W-1:0] off_q;
  logic [7:0]        last_q;
  logic              acc_q;
  logic [FC_W-1:0]   fall_cnt;
  logic [IC_W-1:0]   idle_cnt;
  logic [PC_W-1:0]   prog_cnt;

  logic wr_act, ld_start, ld_end, acc_start, buf_wr, buf_clr, mem_we, buf_vld;
  logic [PAGE_W-1:0] prog_off;
  logic [7:0] buf_data, arr_data;

  assign wr_act    = ~ce_ni & ~we_ni & prot_ni;
  assign data_oe_o = ~ce_ni & ~oe_ni & we_ni & prot_ni;

  eep_strobe u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (wr_act),
    .start_o(ld_start),
    .end_o  (ld_end)
  );

  // open window: first strobe of a page, or a follow-up inside the limit
  assign acc_start = ld_start &&
                     ((st_q == ST_IDLE) ||
                      (st_q == ST_LOAD && fall_cnt < FC_W'(WIN_CYC)));
  assign buf_wr    = ld_end && acc_q;
  assign prog_off  = prog_cnt[PAGE_W-1:0];
  assign buf_clr   = (st_q == ST_PROG) && (prog_cnt == PC_W'(PROG_CYC - 1));
  assign mem_we    = (st_q == ST_PROG) && (prog_cnt < PC_W'(PAGE_B)) &&
                     buf_vld && prot_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      page_q   <= '0;
      off_q    <= '0;
      last_q   <= '0;
      acc_q    <= 1'b0;
      fall_cnt <= '0;
      idle_cnt <= '0;
      prog_cnt <= '0;
    end else begin
      if (acc_start) begin
        acc_q    <= 1'b1;
        off_q    <= addr_i[PAGE_W-1:0];
        fall_cnt <= '0;
        idle_cnt <= '0;
        if (st_q == ST_IDLE) begin
          page_q <= addr_i[ADDR_W-1:PAGE_W];
          st_q   <= ST_LOAD;
        end
      end else if (st_q == ST_LOAD) begin
        if (fall_cnt < FC_W'(WIN_CYC)) fall_cnt <= fall_cnt + 1'b1;
        if (buf_wr) begin
          acc_q    <= 1'b0;
          last_q   <= data_i;
          idle_cnt <= '0;
        end else if (acc_q) begin
          idle_cnt <= '0;
        end else if (idle_cnt == IC_W'(IDLE_CYC - 1)) begin
          st_q     <= ST_PROG;
          prog_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end else if (st_q == ST_PROG) begin
        if (buf_clr) st_q <= ST_IDLE;
        else         prog_cnt <= prog_cnt + 1'b1;
      end
    end
  end

  eep_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (buf_wr),
    .wr_off_i (off_q),
    .wr_data_i(data_i),
    .clr_i    (buf_clr),
    .rd_off_i (prog_off),
    .rd_data_o(buf_data),
    .rd_vld_o (buf_vld)
  );

  eep_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .waddr_i({page_q, prog_off}),
    .wdata_i(buf_data),
    .raddr_i(addr_i),
    .rdata_o(arr_data)
  );

  assign busy_od_o = (st_q != ST_IDLE);

  always_comb begin
    data_o = 8'h00;
    if (data_oe_o) begin
      if (st_q == ST_PROG) data_o = {~last_q[7], last_q[6:0]};
      else                 data_o = arr_data;
    end
  end

  // R5
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_od_o) |-> $past(ld_start));
  // R5
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_od_o) |-> $past(st_q == ST_PROG));
  // R7
  prot_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_ni |-> !data_oe_o);
  // R8
  no_load_in_prog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROG) |=> $stable(page_q));
  // R6
  prog_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROG) |-> (prog_cnt < PC_W'(PROG_CYC)));
  // R3
  commit_only_prog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> $past(st_q != ST_IDLE));
endmodule

// File: tb/eep_page_ctrl_test.sv
`timescale 1ns/1ps
module eep_page_ctrl_test;
  localparam int WIN = 6, IDLE = 20, PROG = 80;

  logic clk = 0, rst_ni = 0;
  logic ce_ni = 1, we_ni = 1, oe_ni = 1, prot_ni = 1;
  logic [7:0] addr_i = 0, data_i = 0;
  logic [7:0] data_o;
  logic data_oe_o, busy_od_o;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] model [256];
  logic [7:0] pend [64];
  logic [63:0] pmask;

  always #2.5 clk = ~clk;

  eep_page_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .prot_ni(prot_ni), .addr_i(addr_i), .data_i(data_i), .data_o(data_o),
    .data_oe_o(data_oe_o), .busy_od_o(busy_od_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog got %0d exp <150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] poll_val(input logic [7:0] d);
    return {~d[7], d[6:0]};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe opens at this negedge, closes two cycles later; start spacing = 3 + gap
  task automatic load(input logic [7:0] a, input logic [7:0] d, input int gap);
    addr_i = a; data_i = d; ce_ni = 0; we_ni = 0;
    @(negedge clk); @(negedge clk);
    ce_ni = 1; we_ni = 1;
    @(negedge clk);
    repeat (gap) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic oe);
    addr_i = a; ce_ni = 0; oe_ni = 0; we_ni = 1;
    #1; d = data_o; oe = data_oe_o;
    ce_ni = 1; oe_ni = 1;
    @(negedge clk);
  endtask

  task automatic page_begin();
    pmask = '0;
  endtask

  task automatic note(input logic [7:0] a, input logic [7:0] d);
    pend[a[5:0]] = d; pmask[a[5:0]] = 1'b1;
  endtask

  task automatic page_commit(input logic [1:0] pg);
    for (int i = 0; i < 64; i++) if (pmask[i]) model[{pg, i[5:0]}] = pend[i];
  endtask

  task automatic verify_page(input logic [1:0] pg, input string req);
    logic [7:0] d; logic oe;
    for (int i = 0; i < 64; i++) begin
      rd({pg, i[5:0]}, d, oe);
      chk(oe && d == model[{pg, i[5:0]}], req, d, model[{pg, i[5:0]}]);
    end
  endtask

  initial begin
    logic [7:0] d, a, lastd;
    logic oe;
    logic [1:0] pg;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    idle(3); rst_ni = 1; idle(2);

    // R9 reset state
    chk(busy_od_o == 0, "R9 busy", {7'd0, busy_od_o}, 8'h00);
    rd(8'h00, d, oe); chk(d == 8'h00, "R9 array", d, 8'h00);
    rd(8'hff, d, oe); chk(d == 8'h00, "R9 array", d, 8'h00);
    // R10 idle bus
    chk(data_oe_o == 0 && data_o == 8'h00, "R10 idle", data_o, 8'h00);

    // R1 R5 R4 R6 single byte
    load(8'h45, 8'h3c, 0);
    chk(busy_od_o == 1, "R5 busy after load", {7'd0, busy_od_o}, 8'h01);
    idle(IDLE + 5);
    rd(8'h00, d, oe); chk(d == poll_val(8'h3c), "R4 poll", d, poll_val(8'h3c));
    chk(busy_od_o == 1, "R5 busy in prog", {7'd0, busy_od_o}, 8'h01);
    idle(PROG);
    chk(busy_od_o == 0, "R5 busy end", {7'd0, busy_od_o}, 8'h00);
    page_begin(); note(8'h45, 8'h3c); page_commit(2'd1);
    verify_page(2'd1, "R6 R1 single");

    // R3 full page, page taken from first load only
    page_begin();
    for (int i = 0; i < 64; i++) begin
      a = {(i == 0) ? 2'd2 : 2'd3, i[5:0]};
      d = 8'(i * 7 + 1);
      load(a, d, 0); note(a, d);
    end
    idle(IDLE + PROG + 10);
    page_commit(2'd2);
    verify_page(2'd2, "R3 R1 full page");
    verify_page(2'd3, "R1 other page");

    // R2 window boundary: gap 3 joins, gap 4 ignored
    page_begin();
    load(8'h00, 8'ha1, 3); note(8'h00, 8'ha1);
    load(8'h01, 8'ha2, 4); note(8'h01, 8'ha2);
    load(8'h02, 8'ha3, 0);
    idle(IDLE + PROG + 10);
    page_commit(2'd0);
    rd(8'h01, d, oe); chk(d == 8'ha2, "R2 in window", d, 8'ha2);
    rd(8'h02, d, oe); chk(d == 8'h00, "R2 late ignored", d, 8'h00);

    // R3 repeated offset, later wins; R4 poll uses last byte
    page_begin();
    load(8'hc5, 8'h11, 1); note(8'hc5, 8'h11);
    load(8'hc5, 8'hf0, 0); note(8'hc5, 8'hf0);
    idle(IDLE + 5);
    rd(8'h10, d, oe); chk(d == poll_val(8'hf0), "R4 poll last", d, poll_val(8'hf0));
    // R8 loads during programming ignored
    load(8'h0a, 8'h77, 0);
    idle(PROG + 10);
    page_commit(2'd3);
    chk(busy_od_o == 0, "R8 no new page", {7'd0, busy_od_o}, 8'h00);
    rd(8'hc5, d, oe); chk(d == 8'hf0, "R3 last wins", d, 8'hf0);
    rd(8'h0a, d, oe); chk(d == model[8'h0a], "R8 ignored", d, model[8'h0a]);

    // R7 protect: loads and reads inhibited
    prot_ni = 0;
    load(8'h20, 8'h55, 0);
    chk(busy_od_o == 0, "R7 load blocked", {7'd0, busy_od_o}, 8'h00);
    rd(8'h05, d, oe);
    chk(oe == 0 && d == 8'h00, "R7 read blocked", d, 8'h00);
    prot_ni = 1;
    rd(8'h20, d, oe); chk(d == model[8'h20], "R7 no write", d, model[8'h20]);
    // R7 commit with protect low leaves array
    load(8'h21, 8'h99, 0);
    prot_ni = 0;
    idle(IDLE + PROG + 10);
    prot_ni = 1;
    rd(8'h21, d, oe); chk(d == model[8'h21], "R7 commit blocked", d, model[8'h21]);

    // random pages
    for (int s = 0; s < 20; s++) begin
      int n;
      pg = 2'($urandom_range(0, 3));
      n = $urandom_range(1, 16);
      page_begin();
      for (int k = 0; k < n; k++) begin
        a = {pg, 6'($urandom_range(0, 63))};
        d = 8'($urandom);
        lastd = d;
        load(a, d, $urandom_range(0, 3)); note(a, d);
      end
      idle(IDLE + 4);
      rd(8'($urandom), d, oe); chk(d == poll_val(lastd), "R4 random poll", d, poll_val(lastd));
      idle(PROG + 6);
      page_commit(pg);
      verify_page(pg, "R3 random page");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule